// File: doc/BRIEF.md
# Serial Image Loader for a Dual-Port Character Store

This block fills a character memory from a byte stream that arrives on a serial receive path. The memory has two ports. The processor keeps the first port to itself, with its timing untouched. The loader drives only the second port, so an image can be placed in memory without any change to the processor's memory logic. The receive path is shared with other traffic. While no load is running, the loader ignores every byte except its own start code.

A load opens with the start code. Three address bytes follow, most significant byte first. After that, each data byte is written to the next location, counting up from that address. Every stored character has its two top bits exchanged. The host sends the word-mark flag in bit 7 and the check bit in bit 6, but memory keeps the check bit in bit 7 and the word-mark flag in bit 6. A load ends in one of two ways: the last location of memory has been written, or the host sends an end marker. Any bytes of a longer image are dropped. A start address that falls outside memory raises an error and writes nothing.

An escape byte frames the data. An escape followed by a second escape stores one literal escape character. An escape followed by any other byte closes the load.

Top module: `ldr_top`

## Requirements
- R1: After reset, wr_en, busy, done and err are all 0.
- R2: While no load is active, a byte other than the start code (default 0x4C) causes no write and leaves busy at 0.
- R3: A start code received while idle raises busy on the next cycle. The next three bytes then form the start address, most significant byte first.
- R4: A start address of MEM_DEPTH or above (all 24 bits compared) sets err, drops busy and writes nothing. err clears when the next start code is accepted.
- R5: Each data byte causes exactly one write, with wr_en high in the cycle after that byte is accepted. Writes go to consecutive addresses, beginning at the start address.
- R6: Every written character equals the received byte with bits 7 and 6 exchanged and bits 5 to 0 unchanged.
- R7: The write to address MEM_DEPTH-1 ends the load. done is high for exactly that one cycle, busy falls, and later data bytes are not written.
- R8: An escape byte (default 0x1B) followed by a second escape writes one escape character at the next address. The escape itself leaves no gap in the addresses.
- R9: An escape followed by any other byte ends the load with a one-cycle done pulse, drops busy and writes nothing.
- R10: While rx_valid is low, no write occurs and the state does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Strobe marking rx_data as a new byte |
| rx_data | input | 8 | Received byte |
| wr_addr | output | $clog2(MEM_DEPTH) | Second-port write address |
| wr_data | output | 8 | Second-port write character, in memory bit order |
| wr_en | output | 1 | Second-port write strobe, one cycle per character |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse when a load completes |
| err | output | 1 | Last start address was out of range |

## Verification
The bound checker enforces four things on every cycle. A write occurs only in a cycle that follows a valid byte accepted while busy. Every write address lies inside memory. Each written character is the previous byte with its two top bits exchanged. done lasts one cycle, never coincides with busy, and no write ever occurs while err is set.

Some behaviours need a defined byte sequence, so only the bench's scenarios can show them:
- the most-significant-first assembly of the start address, including rejection of an address that is out of range only in its top byte;
- the address sequence across an escape pair;
- the end of a load at the last location;
- the clearing of err by a new start code.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    localparam int CHAR_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_ESC  = 2'd3
    } ldr_state_e;

endpackage

// File: rtl/ldr_char_map.sv
// Exchanges two bit positions of a character; all other bits pass straight.
module ldr_char_map #(
    parameter int W     = 8,
    parameter int POS_A = 7,
    parameter int POS_B = 6
) (
    input  logic [W-1:0] chr_in,
    output logic [W-1:0] chr_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == POS_A) begin : g_a
            assign chr_out[i] = chr_in[POS_B];
        end else if (i == POS_B) begin : g_b
            assign chr_out[i] = chr_in[POS_A];
        end else begin : g_keep
            assign chr_out[i] = chr_in[i];
        end
    end
endmodule

// File: rtl/ldr_range_chk.sv
// Bounds test for a candidate start address and last-location test for the pointer.
module ldr_range_chk #(
    parameter int SA_W      = 24,
    parameter int AW        = 16,
    parameter int MEM_DEPTH = 40000
) (
    input  logic [SA_W-1:0] cand,
    input  logic [AW-1:0]   ptr,
    output logic            cand_ok,
    output logic            ptr_last
);
    localparam logic [SA_W-1:0] LIMIT = SA_W'(MEM_DEPTH);
    localparam logic [AW-1:0]   LAST  = AW'(MEM_DEPTH - 1);

    assign cand_ok  = (cand < LIMIT);
    assign ptr_last = (ptr == LAST);
endmodule

// File: rtl/ldr_top.sv
module ldr_top #(
    parameter int          MEM_DEPTH  = 40000,
    parameter int          ADDR_BYTES = 3,
    parameter logic [7:0]  LOAD_CODE  = 8'h4C,
    parameter logic [7:0]  ESC_CODE   = 8'h1B
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    output logic [$clog2(MEM_DEPTH)-1:0] wr_addr,
    output logic [7:0]                   wr_data,
    output logic                         wr_en,
    output logic                         busy,
    output logic                         done,
    output logic                         err
);
    import ldr_pkg::*;

    localparam int AW    = $clog2(MEM_DEPTH);
    localparam int SA_W  = CHAR_BITS * ADDR_BYTES;
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        ldr_state_e           st;
        logic [CNT_W-1:0]     cnt;
        logic [SA_W-1:0]      acc;
        logic [AW-1:0]        ptr;
        logic [AW-1:0]        waddr;
        logic [CHAR_BITS-1:0] wdata;
        logic                 we;
        logic                 busy;
        logic                 done;
        logic                 err;
    } ldr_regs_t;

    ldr_regs_t r_q, r_d;

    logic [CHAR_BITS-1:0] mapped_chr;
    logic [SA_W-1:0]      cand_addr;
    logic                 cand_ok;
    logic                 ptr_last;
    logic                 do_write;

    assign cand_addr = SA_W'({r_q.acc, rx_data});

    ldr_char_map #(
        .W     (CHAR_BITS),
        .POS_A (CHAR_BITS - 1),
        .POS_B (CHAR_BITS - 2)
    ) u_map (
        .chr_in  (rx_data),
        .chr_out (mapped_chr)
    );

    ldr_range_chk #(
        .SA_W      (SA_W),
        .AW        (AW),
        .MEM_DEPTH (MEM_DEPTH)
    ) u_rng (
        .cand     (cand_addr),
        .ptr      (r_q.ptr),
        .cand_ok  (cand_ok),
        .ptr_last (ptr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        do_write = 1'b0;

        if (rx_valid) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (rx_data == LOAD_CODE) begin
                        r_d.st   = ST_ADDR;
                        r_d.cnt  = '0;
                        r_d.acc  = '0;
                        r_d.busy = 1'b1;
                        r_d.err  = 1'b0;
                    end
                end
                ST_ADDR: begin
                    r_d.acc = cand_addr;
                    if (r_q.cnt == CNT_LAST) begin
                        if (cand_ok) begin
                            r_d.ptr = cand_addr[AW-1:0];
                            r_d.st  = ST_DATA;
                        end else begin
                            r_d.err  = 1'b1;
                            r_d.busy = 1'b0;
                            r_d.st   = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (rx_data == ESC_CODE) begin
                        r_d.st = ST_ESC;
                    end else begin
                        do_write = 1'b1;
                    end
                end
                ST_ESC: begin
                    if (rx_data == ESC_CODE) begin
                        r_d.st   = ST_DATA;
                        do_write = 1'b1;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.busy = 1'b0;
                        r_d.st   = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        if (do_write) begin
            r_d.we    = 1'b1;
            r_d.waddr = r_q.ptr;
            r_d.wdata = mapped_chr;
            if (ptr_last) begin
                r_d.done = 1'b1;
                r_d.busy = 1'b0;
                r_d.st   = ST_IDLE;
            end else begin
                r_d.ptr  = r_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_addr = r_q.waddr;
    assign wr_data = r_q.wdata;
    assign wr_en   = r_q.we;
    assign busy    = r_q.busy;
    assign done    = r_q.done;
    assign err     = r_q.err;

endmodule

// File: rtl/ldr_top_chk.sv
module ldr_top_chk #(
    parameter int MEM_DEPTH = 40000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rx_valid,
    input logic [7:0]                   rx_data,
    input logic [$clog2(MEM_DEPTH)-1:0] wr_addr,
    input logic [7:0]                   wr_data,
    input logic                         wr_en,
    input logic                         busy,
    input logic                         done,
    input logic                         err
);
    localparam int AW = $clog2(MEM_DEPTH);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!wr_en && !busy && !done && !err));

    assert_write_needs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(busy));

    assert_idle_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_valid) |-> !wr_en);

    assert_bit_exchange_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == {$past(rx_data[6]), $past(rx_data[7]), $past(rx_data[5:0])}));

    assert_addr_in_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < 32'(MEM_DEPTH)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_err_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!wr_en && !busy));
endmodule

bind ldr_top ldr_top_chk #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/sim_ldr_top.sv
module sim_ldr_top;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_en, busy, done, err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ldr_top #(.MEM_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .busy(busy), .done(done), .err(err)
    );

    // vector: [27:20] byte, [19] we, [18:11] addr, [10:3] data, [2] busy, [1] done, [0] err
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {8'h4C, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R3 start code
        {8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R3 addr high
        {8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R3 addr mid
        {8'h03, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R3 addr low = 3
        {8'h80, 1'b1, 8'h03, 8'h40, 1'b1, 1'b0, 1'b0},  // R5 R6 word-mark bit moves
        {8'h40, 1'b1, 8'h04, 8'h80, 1'b1, 1'b0, 1'b0},  // R5 R6 check bit moves
        {8'hC1, 1'b1, 8'h05, 8'hC1, 1'b1, 1'b0, 1'b0},  // R6 both set
        {8'h1B, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R8 escape held
        {8'h1B, 1'b1, 8'h06, 8'h1B, 1'b1, 1'b0, 1'b0},  // R8 literal escape, no gap
        {8'h1B, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},  // R9 escape
        {8'h55, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0},  // R9 end marker
        {8'h77, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0}   // R2 idle byte ignored
    };

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // drive one byte for one cycle; on return the registered result is visible
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_state(input string tag, input bit e_we, input bit e_busy,
                                input bit e_done, input bit e_err);
        chk(wr_en == e_we,  {tag, " wr_en"}, int'(wr_en), int'(e_we));
        chk(busy  == e_busy, {tag, " busy"}, int'(busy),  int'(e_busy));
        chk(done  == e_done, {tag, " done"}, int'(done),  int'(e_done));
        chk(err   == e_err,  {tag, " err"},  int'(err),   int'(e_err));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1 reset", 0, 0, 0, 0);

        // R10: start code present but strobe low
        rx_data = 8'h4C;
        repeat (3) @(negedge clk);
        expect_state("R10 strobe low", 0, 0, 0, 0);

        // table scenario
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][27:20]);
            expect_state($sformatf("table[%0d]", i), VEC[i][19], VEC[i][2], VEC[i][1], VEC[i][0]);
            if (VEC[i][19]) begin
                chk(8'(wr_addr) == VEC[i][18:11], $sformatf("table[%0d] addr", i),
                    int'(wr_addr), int'(VEC[i][18:11]));
                chk(wr_data == VEC[i][10:3], $sformatf("table[%0d] data", i),
                    int'(wr_data), int'(VEC[i][10:3]));
            end
        end

        // R4: address equal to depth rejected
        send(8'h4C); send(8'h00); send(8'h00); send(8'h10);
        expect_state("R4 addr=depth", 0, 0, 0, 1);
        send(8'h33);
        expect_state("R2 byte after reject", 0, 0, 0, 1);

        // R4: out of range only in top byte
        send(8'h4C);
        expect_state("R4 err cleared by start", 0, 1, 0, 0);
        send(8'h01); send(8'h00); send(8'h00);
        expect_state("R4 top byte reject", 0, 0, 0, 1);

        // R7: start at last location, single write ends the load
        send(8'h4C); send(8'h00); send(8'h00); send(8'h0F);
        expect_state("R3 last-loc start", 0, 1, 0, 0);
        send(8'h12);
        expect_state("R7 last write", 1, 0, 1, 0);
        chk(wr_addr == AW'(DEPTH - 1), "R7 last addr", int'(wr_addr), DEPTH - 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        send(8'h99);
        expect_state("R7 byte after end ignored", 0, 0, 0, 0);

        // R5 R7: full fill from address 0
        send(8'h4C); send(8'h00); send(8'h00); send(8'h00);
        for (int k = 0; k < DEPTH; k++) begin
            logic [7:0] b;
            b = 8'(k * 37 + 8'h21);
            send(b);
            chk(wr_en == 1'b1, "R5 fill write", int'(wr_en), 1);
            chk(wr_addr == AW'(k), "R5 fill addr", int'(wr_addr), k);
            chk(wr_data == {b[6], b[7], b[5:0]}, "R6 fill data",
                int'(wr_data), int'({b[6], b[7], b[5:0]}));
            chk(done == (k == DEPTH - 1), "R7 fill done", int'(done), int'(k == DEPTH - 1));
        end
        send(8'h44);
        expect_state("R7 overflow byte dropped", 0, 0, 0, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule